// File: doc/BRIEF.md
# Page-Boundary Scatter-Gather List Generator

This block turns one transfer request, given as a start address and a byte count, into a list of descriptors. Each descriptor is a start address and a length. No descriptor ever spans a page boundary. The block cuts the first piece at the end of the page that holds the start address. After that it takes one whole page per entry, and the last entry is trimmed to whatever bytes remain. The block writes one entry per clock into a small internal descriptor store.

A requester offers work on a valid/ready handshake, and a new request is taken only while the block is idle. When the walk finishes, a one-cycle `done` pulse marks the final count together with an overflow flag and a scattered flag. The list may hold at most a fixed number of entries. If a request needs more, it ends with an overflow error instead of a silently shortened list. A request with zero bytes produces no entries at all and leaves the scattered flag clear. After the block completes, a consumer fetches entries through an indexed read port that has one cycle of latency.

Top module: `sg_page_splitter`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. Any request offered while the block is busy is ignored and changes neither the list nor the timing of `done`.
- R2: Entry 0 starts at the request address. Its length is the smaller of the byte count and `PAGE_BYTES - (address mod PAGE_BYTES)`.
- R3: Every entry after entry 0 starts on a multiple of `PAGE_BYTES`, and its length is the smaller of the remaining byte count and `PAGE_BYTES`. Addresses wrap modulo 2^32.
- R4: When no overflow occurs, the lengths of all entries add up to exactly the requested byte count, so the last entry may be shorter than a page.
- R5: At most `MAX_ENTRIES` (default 33) entries are produced. A request that needs more stores `MAX_ENTRIES` entries and reports `overflow` = 1 and `entry_count` = `MAX_ENTRIES` at `done`.
- R6: A zero-byte request writes no entry. It reports `entry_count` = 0, `overflow` = 0 and `scattered` = 0.
- R7: One entry is written per clock. For a request that yields N entries, `done` is high in the clock cycle that begins N rising edges after the accepting edge. For N = 0 this is the cycle right after acceptance.
- R8: `done` lasts exactly one cycle. `entry_count`, `overflow` and `scattered` keep their final values until the next request is accepted.
- R9: `rd_data` shows the entry at `rd_idx` one clock after `rd_idx` is presented. The address sits in bits [31:0] and the length in bits [63:32]. Both are little-endian, so byte lane k (bits 8k+7:8k) holds the least significant remaining byte: lane 0 is the address LSB and lane 4 is the length LSB.
- R10: At `done`, `scattered` is 1 exactly when at least one entry was written and no overflow occurred.
- R11: After reset, `req_ready` = 1, `done` = 0, `entry_count` = 0, `overflow` = 0 and `scattered` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Transfer start address |
| req_bytes | input | 32 | Transfer length in bytes |
| rd_idx | input | $clog2(MAX_ENTRIES) | Descriptor index to fetch |
| rd_data | output | 64 | Fetched descriptor, little-endian {length, address} |
| done | output | 1 | One-cycle completion pulse |
| entry_count | output | $clog2(MAX_ENTRIES+1) | Number of entries written |
| overflow | output | 1 | Request needed more than MAX_ENTRIES entries |
| scattered | output | 1 | A non-empty, complete list was produced |

## Verification
A wrong page offset or a wrong remaining-byte register shows up in two ways. The stored lengths change, and the entry count changes too, which moves the `done` pulse by one or more cycles. Because `req_ready` and `done` are compared on every clock, a counter or state error is reported in the first cycle where the timing differs. Errors in the contents, such as a misaligned later entry, a wrong clamp or a swapped byte lane, appear during the readback that follows each `done`. The overflow limit, the zero-length case and address wrap are each exercised by a dedicated request.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

    localparam int DESC_ADDR_W = 32;
    localparam int DESC_LEN_W  = 32;
    localparam int DESC_W      = DESC_ADDR_W + DESC_LEN_W;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_WALK = 2'd1,
        WK_FIN  = 2'd2
    } walk_state_t;

    typedef struct packed {
        logic [DESC_LEN_W-1:0]  len;
        logic [DESC_ADDR_W-1:0] addr;
    } seg_desc_t;

    // Little-endian word layout: lane k of each field keeps byte k.
    function automatic logic [DESC_W-1:0] desc_to_word(input seg_desc_t d);
        logic [DESC_W-1:0] w;
        w = '0;
        for (int b = 0; b < DESC_ADDR_W/8; b++) begin
            w[8*b +: 8] = d.addr[8*b +: 8];
        end
        for (int b = 0; b < DESC_LEN_W/8; b++) begin
            w[DESC_ADDR_W + 8*b +: 8] = d.len[8*b +: 8];
        end
        return w;
    endfunction

    function automatic logic [DESC_LEN_W-1:0] min_len(input logic [DESC_LEN_W-1:0] a,
                                                      input logic [DESC_LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sgl_page_cut.sv
module sgl_page_cut
    import sgl_pkg::*;
#(
    parameter int PAGE_BYTES = 4096
) (
    input  logic [DESC_ADDR_W-1:0] cur_addr,
    input  logic [DESC_LEN_W-1:0]  remain,
    output logic [DESC_LEN_W-1:0]  seg_len,
    output logic                   seg_last
);
    localparam logic [DESC_ADDR_W-1:0] OFS_MASK = DESC_ADDR_W'(PAGE_BYTES - 1);
    localparam logic [DESC_LEN_W-1:0]  PAGE_L   = DESC_LEN_W'(PAGE_BYTES);

    logic [DESC_LEN_W-1:0] to_page_end;

    always_comb begin
        to_page_end = PAGE_L - DESC_LEN_W'(cur_addr & OFS_MASK);
        seg_len     = min_len(remain, to_page_end);
        seg_last    = (seg_len == remain);
    end
endmodule

// File: rtl/sgl_desc_ram.sv
module sgl_desc_ram
    import sgl_pkg::*;
#(
    parameter int DEPTH = 33,
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DESC_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DESC_W-1:0] rd_word
);
    localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

    logic [DESC_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_idx} < DEPTH_L)) begin
            store[wr_idx] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if ({1'b0, rd_idx} < DEPTH_L) begin
            rd_word <= store[rd_idx];
        end else begin
            rd_word <= '0;
        end
    end
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
    import sgl_pkg::*;
#(
    parameter int PAGE_BYTES  = 4096,
    parameter int MAX_ENTRIES = 33,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [DESC_ADDR_W-1:0] req_addr,
    input  logic [DESC_LEN_W-1:0]  req_bytes,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output seg_desc_t              wr_desc,
    output logic                   done,
    output logic [CNT_W-1:0]       entry_count,
    output logic                   overflow,
    output logic                   scattered
);
    localparam logic [CNT_W-1:0]       LAST_SLOT = CNT_W'(MAX_ENTRIES - 1);
    localparam logic [CNT_W-1:0]       CAP       = CNT_W'(MAX_ENTRIES);
    localparam logic [DESC_ADDR_W-1:0] OFS_MASK  = DESC_ADDR_W'(PAGE_BYTES - 1);
    localparam logic [DESC_LEN_W:0]    PAGE_X    = (DESC_LEN_W+1)'(PAGE_BYTES);

    walk_state_t            state;
    logic [DESC_ADDR_W-1:0] cur_addr;
    logic [DESC_LEN_W-1:0]  remain;
    logic [CNT_W-1:0]       idx;
    logic                   ovf_q;
    logic                   scat_q;
    logic [DESC_LEN_W-1:0]  seg_len;
    logic                   seg_last;
    logic                   take;

    sgl_page_cut #(.PAGE_BYTES(PAGE_BYTES)) u_cut (
        .cur_addr (cur_addr),
        .remain   (remain),
        .seg_len  (seg_len),
        .seg_last (seg_last)
    );

    assign req_ready    = (state == WK_IDLE);
    assign take         = req_valid && req_ready;
    assign done         = (state == WK_FIN);
    assign entry_count  = idx;
    assign overflow     = ovf_q;
    assign scattered    = scat_q;
    assign wr_en        = (state == WK_WALK);
    assign wr_idx       = IDX_W'(idx);
    assign wr_desc.addr = cur_addr;
    assign wr_desc.len  = seg_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WK_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            idx      <= '0;
            ovf_q    <= 1'b0;
            scat_q   <= 1'b0;
        end else begin
            case (state)
                WK_IDLE: begin
                    if (take) begin
                        cur_addr <= req_addr;
                        remain   <= req_bytes;
                        idx      <= '0;
                        ovf_q    <= 1'b0;
                        scat_q   <= 1'b0;
                        state    <= (req_bytes == '0) ? WK_FIN : WK_WALK;
                    end
                end
                WK_WALK: begin
                    idx      <= idx + 1'b1;
                    remain   <= remain - seg_len;
                    cur_addr <= cur_addr + seg_len;
                    if (seg_last) begin
                        scat_q <= 1'b1;
                        state  <= WK_FIN;
                    end else if (idx == LAST_SLOT) begin
                        ovf_q  <= 1'b1;
                        state  <= WK_FIN;
                    end
                end
                WK_FIN:  state <= WK_IDLE;
                default: state <= WK_IDLE;
            endcase
        end
    end

    // R2: a written entry is never empty and never runs past its page end
    p_entry_in_page_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_desc.len != '0) &&
                  (({1'b0, wr_desc.addr & OFS_MASK} + {1'b0, wr_desc.len}) <= PAGE_X));

    // R3: entries after the first start on a page boundary
    p_later_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |-> ((wr_desc.addr & OFS_MASK) == '0));

    // R5: the count never exceeds the list capacity
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        entry_count <= CAP);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: an empty list never carries the scattered flag
    p_empty_flat_r10: assert property (@(posedge clk) disable iff (rst)
        (done && entry_count == '0) |-> !scattered);

    // R1: once a request is taken the block stops offering ready
    p_busy_after_take_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/sg_page_splitter.sv
module sg_page_splitter
    import sgl_pkg::*;
#(
    parameter int PAGE_BYTES  = 4096,
    parameter int MAX_ENTRIES = 33,
    localparam int IDX_W      = $clog2(MAX_ENTRIES),
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [DESC_ADDR_W-1:0] req_addr,
    input  logic [DESC_LEN_W-1:0]  req_bytes,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DESC_W-1:0]      rd_data,
    output logic                   done,
    output logic [CNT_W-1:0]       entry_count,
    output logic                   overflow,
    output logic                   scattered
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    seg_desc_t        wr_desc;

    sgl_walker #(
        .PAGE_BYTES  (PAGE_BYTES),
        .MAX_ENTRIES (MAX_ENTRIES),
        .IDX_W       (IDX_W),
        .CNT_W       (CNT_W)
    ) u_walk (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_bytes   (req_bytes),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_desc     (wr_desc),
        .done        (done),
        .entry_count (entry_count),
        .overflow    (overflow),
        .scattered   (scattered)
    );

    sgl_desc_ram #(
        .DEPTH (MAX_ENTRIES),
        .IDX_W (IDX_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (desc_to_word(wr_desc)),
        .rd_idx  (rd_idx),
        .rd_word (rd_data)
    );
endmodule

// File: tb/sim_sg_page_splitter.sv
module sim_sg_page_splitter;
    localparam int PAGE  = 4096;
    localparam int MAXE  = 33;
    localparam int IDX_W = $clog2(MAXE);
    localparam int CNT_W = $clog2(MAXE + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic [31:0]      req_bytes = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [63:0]      rd_data;
    logic             done;
    logic [CNT_W-1:0] entry_count;
    logic             overflow;
    logic             scattered;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sg_page_splitter #(.PAGE_BYTES(PAGE), .MAX_ENTRIES(MAXE)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .rd_idx(rd_idx),
        .rd_data(rd_data), .done(done), .entry_count(entry_count),
        .overflow(overflow), .scattered(scattered)
    );

    // Behavioural reference model
    longint exp_a[$];
    longint exp_l[$];
    bit     m_busy = 0;
    bit     m_done = 0;
    int     m_left = 0;
    int     m_n    = 0;
    bit     m_ovf  = 0;

    task automatic build_list(input longint a0, input longint b0);
        longint a, rem, len;
        a = a0; rem = b0;
        exp_a.delete(); exp_l.delete();
        m_n = 0; m_ovf = 0;
        while (rem > 0) begin
            if (m_n == MAXE) begin m_ovf = 1; break; end
            len = PAGE - (a % PAGE);
            if (len > rem) len = rem;
            exp_a.push_back(a);
            exp_l.push_back(len);
            a = (a + len) % 64'h1_0000_0000;
            rem = rem - len;
            m_n++;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_left = 0;
        end else if (m_done) begin
            m_done = 0; m_busy = 0;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) m_done = 1;
        end else if (req_valid) begin
            build_list(longint'(req_addr), longint'(req_bytes));
            m_busy = 1;
            m_left = m_n;
            if (m_n == 0) m_done = 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every-clock comparison of handshake and completion timing
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(req_ready == !m_busy, "R1 req_ready", longint'(req_ready), longint'(!m_busy));
            check(done == m_done, "R7 done timing", longint'(done), longint'(m_done));
            if (m_done && done) begin
                check(entry_count == CNT_W'(m_n), "R5 count at done", longint'(entry_count), longint'(m_n));
                check(overflow == m_ovf, "R5 overflow at done", longint'(overflow), longint'(m_ovf));
                check(scattered == (m_n > 0 && !m_ovf), "R10 scattered at done",
                      longint'(scattered), longint'(m_n > 0 && !m_ovf));
            end
        end
    end

    task automatic run_req(input logic [31:0] a, input logic [31:0] b, input bit junk);
        longint sum;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = a; req_bytes = b;
        @(negedge clk);
        // R1: requests offered while busy must be ignored
        req_valid = junk; req_addr = ~a; req_bytes = 32'd5;
        while (!m_done) @(negedge clk);
        req_valid = 0;
        sum = 0;
        for (int i = 0; i < m_n; i++) begin
            rd_idx = IDX_W'(i);
            @(negedge clk);
            check(rd_data[31:0] == exp_a[i][31:0], (i == 0) ? "R2 entry addr" : "R3 entry addr",
                  longint'(rd_data[31:0]), exp_a[i]);
            check(rd_data[63:32] == exp_l[i][31:0], (i == 0) ? "R2 entry len" : "R3 entry len",
                  longint'(rd_data[63:32]), exp_l[i]);
            check(rd_data[7:0] == exp_a[i][7:0] && rd_data[39:32] == exp_l[i][7:0],
                  "R9 little-endian lanes", longint'({rd_data[39:32], rd_data[7:0]}),
                  longint'({exp_l[i][7:0], exp_a[i][7:0]}));
            sum += longint'(rd_data[63:32]);
        end
        if (!m_ovf)
            check(sum == longint'(b), "R4 length sum", sum, longint'(b));
        if (m_n == 0)
            check(entry_count == 0 && !overflow && !scattered, "R6 zero request",
                  longint'({entry_count, overflow, scattered}), 0);
        check(entry_count == CNT_W'(m_n) && overflow == m_ovf &&
              scattered == (m_n > 0 && !m_ovf), "R8 held results",
              longint'({entry_count, overflow, scattered}),
              longint'({CNT_W'(m_n), m_ovf, (m_n > 0 && !m_ovf)}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready && !done && entry_count == 0 && !overflow && !scattered, "R11 reset state",
              longint'({req_ready, done, entry_count, overflow, scattered}), longint'({1'b1, 1'b0, CNT_W'(0), 2'b00}));
        rst = 0;
        run_req(32'h0000_1000, 32'd12288, 1'b0);   // aligned, whole pages
        run_req(32'h0000_0FF0, 32'h20, 1'b1);      // straddles one boundary
        run_req(32'h0000_2345, 32'h10, 1'b1);      // inside one page
        run_req(32'h0000_5000, 32'd0, 1'b1);       // R6 zero length
        run_req(32'h0000_0000, 32'd135168, 1'b0);  // exactly 33 pages
        run_req(32'h0000_0100, 32'd135168, 1'b1);  // needs 34: R5 overflow
        run_req(32'hFFFF_F800, 32'h1000, 1'b0);    // R3 address wrap
        run_req(32'h1234_5678, 32'hFFFF_FFFF, 1'b1); // huge: R5 overflow
        run_req(32'h0000_0FFF, 32'h1002, 1'b0);    // 1-byte head, 1-byte tail
        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule